// File: doc/BRIEF.md
# Processor Power Mode Controller

This block moves a processor between six states: full-on, active (PLL bypassed), sleep, deep sleep, hibernate and a hardware reset sequence. It runs on an always-on clock, so it keeps working while the core and system clocks are gated. It drives the core clock enable, the system clock enable, the core power request, the external regulator wake line, a system reset output and the SDRAM self-refresh request. The PLL, the regulator, the RTC and the SDRAM controller are outside the block. Only their handshake lines reach it.

Software requests transitions through a 3-bit command input. It also writes a regulator control register, which the block owns. That register holds the frequency field, the per-source wake enables and the self-refresh bit. Only power-on reset clears it, so it keeps its contents through hibernate and through the reset sequence that follows. The asynchronous wake pins pass through a synchronizer before the state machine sees them.

Where a wake leads depends on the state being left and on the event that caused it. A wake from hibernate never resumes directly. It always runs the full reset sequence first.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low), `mode_o` is 0 (full-on). `cclk_en_o`, `sclk_en_o`, `core_pwr_req_o` and `ext_wake_o` are high, and `sys_rst_o` and `sdram_sr_o` are low.
- R2: Command 3'd1 (sleep) from full-on takes effect on the next clock edge. The result is `mode_o`=2, with `cclk_en_o` low and `sclk_en_o` high.
- R3: In sleep, an RTC wake (`rtc_wake_i` high) or the external wake pin going low is acted on at the third rising edge after the input changes. Each of these inputs passes through two synchronizer flops. The block goes to full-on (0) when `pll_byp_i` is low, and to active (1) when it is high.
- R4: Command 3'd2 (deep sleep) gives `mode_o`=3 with both clock enables low. In deep sleep the external wake pin has no effect. An RTC wake moves the block to active (1).
- R5: In active with `pll_en_i` low, command 3'd3 (full-on) and command 3'd1 (sleep) are refused and `mode_o` stays 1. With `pll_en_i` high, command 3'd3 moves the block to full-on.
- R6: A regulator write (`vr_wr_i`) is accepted in full-on or active. If the written frequency is 2'b00, the block enters hibernate (`mode_o`=4). In hibernate `core_pwr_req_o`, `ext_wake_o` and both clock enables are low. A write with a nonzero frequency leaves the mode unchanged.
- R7: In hibernate, the external pin wakes the block only if wake-enable bit 0 is set, and the RTC wakes it only if wake-enable bit 1 is set. A source whose enable bit is clear is ignored.
- R8: A hibernate wake enters the reset sequence (`mode_o`=5). `ext_wake_o` goes high at once, and `sys_rst_o` stays high for exactly 16 clock cycles. The block then returns to full-on.
- R9: A low level on `hw_reset_n_i` in any state starts the reset sequence. This includes deep sleep, and hibernate with no wake source enabled. The sequence is held for as long as the pin stays low, and then ends in full-on.
- R10: With the self-refresh bit set, `sdram_sr_o` is high in hibernate and through the reset sequence that follows it. It drops when full-on is reached. With the bit clear, `sdram_sr_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| pll_en_i | input | 1 | PLL enable bit |
| pll_byp_i | input | 1 | PLL bypass bit |
| cmd_i | input | 3 | Mode command: 1 sleep, 2 deep sleep, 3 full-on, 4 active, others none |
| vr_wr_i | input | 1 | Regulator register write strobe |
| vr_freq_i | input | 2 | Regulator frequency field; 2'b00 requests hibernate |
| vr_wake_en_i | input | 2 | Hibernate wake enables: bit 0 external pin, bit 1 RTC |
| vr_sref_i | input | 1 | SDRAM self-refresh hold bit |
| rtc_wake_i | input | 1 | RTC wake, active high, asynchronous |
| ext_wake_n_i | input | 1 | External / PHY interrupt wake pin, active low, asynchronous |
| hw_reset_n_i | input | 1 | Reset pin, active low, asynchronous |
| cclk_en_o | output | 1 | Core clock enable |
| sclk_en_o | output | 1 | System clock enable |
| core_pwr_req_o | output | 1 | Core supply request |
| ext_wake_o | output | 1 | External regulator wake; low means shut down |
| sys_rst_o | output | 1 | Hardware reset output during the reset sequence |
| sdram_sr_o | output | 1 | SDRAM self-refresh request |
| mode_o | output | 3 | Current state: 0 full-on, 1 active, 2 sleep, 3 deep, 4 hibernate, 5 reset sequence |

## Verification
The bench builds the block with its defaults: a 16-cycle reset sequence and two synchronizer stages. With a 16-cycle sequence, the bench can count every cycle of reset assertion and compare the total exactly. With two stages, every asynchronous wake lands on a fixed third edge, so the bench can check both the cycle before the change and the cycle of the change. At these sizes the bench also reaches the held-pin case of the reset sequence and the pairing of each wake source with its enable bit.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PM_FULL   = 3'd0,
    PM_ACTIVE = 3'd1,
    PM_SLEEP  = 3'd2,
    PM_DEEP   = 3'd3,
    PM_HIBER  = 3'd4,
    PM_RSTSEQ = 3'd5
  } pm_state_e;

  localparam logic [2:0] CMD_SLEEP  = 3'd1;
  localparam logic [2:0] CMD_DEEP   = 3'd2;
  localparam logic [2:0] CMD_FULL   = 3'd3;
  localparam logic [2:0] CMD_ACTIVE = 3'd4;

  typedef struct packed {
    logic cclk;
    logic sclk;
    logic pwr;
    logic ext;
    logic rst;
  } pm_out_t;

  function automatic pm_out_t pm_decode(pm_state_e s);
    pm_out_t o;
    o = '{cclk: 1'b1, sclk: 1'b1, pwr: 1'b1, ext: 1'b1, rst: 1'b0};
    case (s)
      PM_SLEEP:  o.cclk = 1'b0;
      PM_DEEP:   begin o.cclk = 1'b0; o.sclk = 1'b0; end
      PM_HIBER:  begin o.cclk = 1'b0; o.sclk = 1'b0; o.pwr = 1'b0; o.ext = 1'b0; end
      PM_RSTSEQ: begin o.cclk = 1'b0; o.sclk = 1'b0; o.rst = 1'b1; end
      default:   ;
    endcase
    return o;
  endfunction

  function automatic pm_state_e pm_sleep_target(logic bypass);
    return bypass ? PM_ACTIVE : PM_FULL;
  endfunction

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/pmc_rst_timer.sv
module pmc_rst_timer #(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic done_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (hold_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = !hold_i && (cnt_q == LAST);
endmodule

// File: rtl/pmc_vr_reg.sv
module pmc_vr_reg #(
  parameter int FW = 2,
  parameter int EW = 2,
  parameter logic [FW-1:0] FREQ_RST = 2'b10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [FW-1:0] freq_i,
  input  logic [EW-1:0] wake_en_i,
  input  logic          sref_i,
  output logic [FW-1:0] freq_o,
  output logic [EW-1:0] wake_en_o,
  output logic          sref_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_o    <= FREQ_RST;
      wake_en_o <= '0;
      sref_o    <= 1'b0;
    end else if (wr_i) begin
      freq_o    <= freq_i;
      wake_en_o <= wake_en_i;
      sref_o    <= sref_i;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int RST_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_aon,
  input  logic       rst_n,
  input  logic       pll_en_i,
  input  logic       pll_byp_i,
  input  logic [2:0] cmd_i,
  input  logic       vr_wr_i,
  input  logic [1:0] vr_freq_i,
  input  logic [1:0] vr_wake_en_i,
  input  logic       vr_sref_i,
  input  logic       rtc_wake_i,
  input  logic       ext_wake_n_i,
  input  logic       hw_reset_n_i,
  output logic       cclk_en_o,
  output logic       sclk_en_o,
  output logic       core_pwr_req_o,
  output logic       ext_wake_o,
  output logic       sys_rst_o,
  output logic       sdram_sr_o,
  output logic [2:0] mode_o
);
  localparam int NSYNC = 3;

  pm_state_e state_q, state_d;
  logic [NSYNC-1:0] raw_pins, sync_pins;
  logic rtc_s, ext_s, rst_pin_s;
  logic [1:0] freq_q;
  logic [1:0] wen_q;
  logic sref_q;
  logic hib_chain_q;
  logic rst_done;
  logic in_run;
  logic wr_ok;

  // named events, also used by the checker
  logic hib_enter, sleep_wake, deep_wake, hib_wake, pll_refused;

  assign raw_pins = {hw_reset_n_i, ext_wake_n_i, rtc_wake_i};

  pmc_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk_aon), .rst_n(rst_n), .d(raw_pins), .q(sync_pins)
  );

  assign rtc_s     = sync_pins[0];
  assign ext_s     = !sync_pins[1];
  assign rst_pin_s = !sync_pins[2];

  assign in_run = (state_q == PM_FULL) || (state_q == PM_ACTIVE);
  assign wr_ok  = vr_wr_i && in_run;

  pmc_vr_reg #(.FW(2), .EW(2), .FREQ_RST(2'b10)) u_vr (
    .clk(clk_aon), .rst_n(rst_n), .wr_i(wr_ok),
    .freq_i(vr_freq_i), .wake_en_i(vr_wake_en_i), .sref_i(vr_sref_i),
    .freq_o(freq_q), .wake_en_o(wen_q), .sref_o(sref_q)
  );

  pmc_rst_timer #(.N(RST_CYCLES)) u_tmr (
    .clk(clk_aon), .rst_n(rst_n),
    .hold_i((state_q != PM_RSTSEQ) || rst_pin_s),
    .done_o(rst_done)
  );

  assign hib_enter   = wr_ok && (vr_freq_i == 2'b00);
  assign sleep_wake  = (state_q == PM_SLEEP) && (rtc_s || ext_s);
  assign deep_wake   = (state_q == PM_DEEP) && rtc_s;
  assign hib_wake    = (state_q == PM_HIBER) &&
                       ((ext_s && wen_q[0]) || (rtc_s && wen_q[1]));
  assign pll_refused = (state_q == PM_ACTIVE) && !pll_en_i &&
                       ((cmd_i == CMD_FULL) || (cmd_i == CMD_SLEEP));

  always_comb begin
    state_d = state_q;
    if (rst_pin_s) begin
      state_d = PM_RSTSEQ;
    end else begin
      case (state_q)
        PM_FULL, PM_ACTIVE: begin
          if (hib_enter)                             state_d = PM_HIBER;
          else if (cmd_i == CMD_DEEP)                state_d = PM_DEEP;
          else if (pll_refused)                      state_d = state_q;
          else if (cmd_i == CMD_SLEEP)               state_d = PM_SLEEP;
          else if (cmd_i == CMD_FULL)                state_d = PM_FULL;
          else if (cmd_i == CMD_ACTIVE)              state_d = PM_ACTIVE;
        end
        PM_SLEEP:  if (sleep_wake) state_d = pm_sleep_target(pll_byp_i);
        PM_DEEP:   if (deep_wake)  state_d = PM_ACTIVE;
        PM_HIBER:  if (hib_wake)   state_d = PM_RSTSEQ;
        PM_RSTSEQ: if (rst_done)   state_d = PM_FULL;
        default:   state_d = PM_FULL;
      endcase
    end
  end

  always_ff @(posedge clk_aon or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PM_FULL;
      hib_chain_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d == PM_HIBER)     hib_chain_q <= 1'b1;
      else if (state_d != PM_RSTSEQ) hib_chain_q <= 1'b0;
    end
  end

  pm_out_t outs;
  assign outs = pm_decode(state_q);

  assign cclk_en_o      = outs.cclk;
  assign sclk_en_o      = outs.sclk;
  assign core_pwr_req_o = outs.pwr;
  assign ext_wake_o     = outs.ext;
  assign sys_rst_o      = outs.rst;
  assign sdram_sr_o     = sref_q && hib_chain_q &&
                          ((state_q == PM_HIBER) || (state_q == PM_RSTSEQ));
  assign mode_o         = state_q;

  logic unused_freq;
  assign unused_freq = ^freq_q;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       cclk_en,
  input logic       sclk_en,
  input logic       pwr_req,
  input logic       ext_wake,
  input logic       sys_rst,
  input logic       pll_en,
  input logic       hib_wake,
  input logic       rst_pin
);
  AST_SLEEP_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |-> (!cclk_en && sclk_en)); // R2

  AST_DEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 3'd3 && mode != 3'd3) |-> (mode == 3'd1 || mode == 3'd5)); // R4

  AST_PLL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 3'd1 && !$past(pll_en)) |-> (mode != 3'd0 && mode != 3'd2)); // R5

  AST_HIBER_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |-> (!pwr_req && !ext_wake && !cclk_en && !sclk_en)); // R6

  AST_HIBER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 3'd4 && mode != 3'd4) |-> (mode == 3'd5)); // R8

  AST_HIB_WAKE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (hib_wake && !rst_pin) |=> (mode == 3'd5 && ext_wake && sys_rst)); // R8

  AST_PIN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pin |=> (mode == 3'd5)); // R9

  AST_SEQ_TO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (mode == 3'd0)); // R9
endmodule

bind pwr_mode_ctrl pmc_chk u_chk (
  .clk(clk_aon), .rst_n(rst_n), .mode(mode_o),
  .cclk_en(cclk_en_o), .sclk_en(sclk_en_o), .pwr_req(core_pwr_req_o),
  .ext_wake(ext_wake_o), .sys_rst(sys_rst_o), .pll_en(pll_en_i),
  .hib_wake(hib_wake), .rst_pin(rst_pin_s)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic pll_en, pll_byp;
  logic [2:0] cmd;
  logic vr_wr;
  logic [1:0] vr_freq, vr_wen;
  logic vr_sref;
  logic rtc, ext_n, hw_rst_n;
  logic cclk_en, sclk_en, pwr_req, ext_wake, sys_rst, sdram_sr;
  logic [2:0] mode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk_aon(clk), .rst_n(rst_n), .pll_en_i(pll_en), .pll_byp_i(pll_byp),
    .cmd_i(cmd), .vr_wr_i(vr_wr), .vr_freq_i(vr_freq), .vr_wake_en_i(vr_wen),
    .vr_sref_i(vr_sref), .rtc_wake_i(rtc), .ext_wake_n_i(ext_n),
    .hw_reset_n_i(hw_rst_n), .cclk_en_o(cclk_en), .sclk_en_o(sclk_en),
    .core_pwr_req_o(pwr_req), .ext_wake_o(ext_wake), .sys_rst_o(sys_rst),
    .sdram_sr_o(sdram_sr), .mode_o(mode)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_cmd(logic [2:0] c);
    cmd = c;
    step(1);
    cmd = 3'd0;
  endtask

  task automatic vr_write(logic [1:0] f, logic [1:0] w, logic s);
    vr_wr = 1'b1; vr_freq = f; vr_wen = w; vr_sref = s;
    step(1);
    vr_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 mode", mode, 0);
    chk("R1 clocks", {cclk_en, sclk_en, pwr_req, ext_wake}, 4'b1111);
    chk("R1 rst/sr", {sys_rst, sdram_sr}, 2'b00);
  endtask

  task automatic t_sleep;
    pll_byp = 1'b0;
    send_cmd(3'd1);
    chk("R2 sleep mode", mode, 2);
    chk("R2 sleep clocks", {cclk_en, sclk_en}, 2'b01);
    rtc = 1'b1;
    step(2);
    chk("R3 wake latency", mode, 2);
    step(1);
    chk("R3 bypass clear", mode, 0);
    rtc = 1'b0; step(3);
    send_cmd(3'd1);
    pll_byp = 1'b1;
    ext_n = 1'b0;
    step(3);
    chk("R3 bypass set", mode, 1);
    ext_n = 1'b1; step(3);
  endtask

  task automatic t_pll_guard;
    pll_en = 1'b0;
    send_cmd(3'd3);
    chk("R5 full refused", mode, 1);
    send_cmd(3'd1);
    chk("R5 sleep refused", mode, 1);
    pll_en = 1'b1;
    send_cmd(3'd3);
    chk("R5 full accepted", mode, 0);
  endtask

  task automatic t_deep;
    send_cmd(3'd2);
    chk("R4 deep mode", mode, 3);
    chk("R4 deep clocks", {cclk_en, sclk_en}, 2'b00);
    ext_n = 1'b0; step(5);
    chk("R4 pin ignored", mode, 3);
    ext_n = 1'b1; step(3);
    rtc = 1'b1; step(3);
    chk("R4 rtc to active", mode, 1);
    rtc = 1'b0; step(3);
    send_cmd(3'd3);
  endtask

  task automatic t_deep_reset;
    send_cmd(3'd2);
    hw_rst_n = 1'b0; step(3);
    chk("R9 reset from deep", mode, 5);
    chk("R9 sys_rst", sys_rst, 1);
    step(30);
    chk("R9 held by pin", mode, 5);
    hw_rst_n = 1'b1; step(10);
    chk("R9 still in seq", mode, 5);
    step(15);
    chk("R9 ends full-on", mode, 0);
  endtask

  task automatic t_vr_nonzero;
    vr_write(2'b01, 2'b00, 1'b0);
    chk("R6 nonzero freq", mode, 0);
  endtask

  task automatic t_hib_ext;
    vr_write(2'b00, 2'b01, 1'b1);
    chk("R6 hib mode", mode, 4);
    chk("R6 hib outputs", {pwr_req, ext_wake, cclk_en, sclk_en}, 4'b0000);
    chk("R10 sr in hib", sdram_sr, 1);
    rtc = 1'b1; step(5);
    chk("R7 rtc disabled", mode, 4);
    rtc = 1'b0; step(3);
    ext_n = 1'b0; step(3);
    chk("R8 seq entered", mode, 5);
    chk("R8 ext_wake high", ext_wake, 1);
    chk("R10 sr in seq", sdram_sr, 1);
    ext_n = 1'b1;
    begin
      int n = 0;
      while (sys_rst && n < 100) begin
        n++;
        step(1);
      end
      chk("R8 reset length", n, 16);
    end
    chk("R8 back to full", mode, 0);
    chk("R10 sr cleared", sdram_sr, 0);
    step(3);
  endtask

  task automatic t_hib_rtc;
    vr_write(2'b00, 2'b10, 1'b0);
    chk("R10 sr bit clear", sdram_sr, 0);
    ext_n = 1'b0; step(5);
    chk("R7 pin disabled", mode, 4);
    ext_n = 1'b1; step(3);
    rtc = 1'b1; step(3);
    chk("R7 rtc enabled wake", mode, 5);
    rtc = 1'b0;
    step(20);
    chk("R8 rtc seq done", mode, 0);
  endtask

  task automatic t_hib_reset;
    vr_write(2'b00, 2'b00, 1'b0);
    chk("R9 hib no enables", mode, 4);
    hw_rst_n = 1'b0; step(3);
    chk("R9 pin wakes hib", mode, 5);
    hw_rst_n = 1'b1; step(25);
    chk("R9 hib reset done", mode, 0);
  endtask

  initial begin
    rst_n = 1'b0; pll_en = 1'b1; pll_byp = 1'b0; cmd = 3'd0;
    vr_wr = 1'b0; vr_freq = 2'b10; vr_wen = 2'b00; vr_sref = 1'b0;
    rtc = 1'b0; ext_n = 1'b1; hw_rst_n = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_sleep();
    t_pll_guard();
    t_deep();
    t_deep_reset();
    t_vr_nonzero();
    t_hib_ext();
    t_hib_rtc();
    t_hib_reset();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule